// File: doc/BRIEF.md
# Serial Register Slave with Readback

This block is a four-wire serial slave, selected by an active-low chip select, that gives a host access to a small bank of 8-bit control registers. Every access is a 16-bit frame. The first byte is the command: a direction flag, then a 7-bit address. The second byte carries the write data, or returns the read data. The serial clock, chip select and data input are brought into the system clock domain through a two-flop synchroniser, and their edges are detected there. The system clock must therefore run several times faster than the serial clock.

A write takes effect only when chip select is released after exactly sixteen serial clocks. A frame that is too short or too long is discarded. A read drives the selected register onto the serial output during the second byte, most significant bit first. The output is high-impedance whenever the slave is not selected. The stored fields also appear as parallel outputs for the gain and power logic next to the block.

Top module: `spi_regfile_slave`

## Requirements
- R1: Driving chip select low starts a new frame and clears any partial frame. A frame aborted early has no effect, and the next full frame works normally.
- R2: Input data is sampled on rising serial clock edges. Output data changes only on falling edges. Frame bit 15 goes first and is the direction flag (1 = read, 0 = write). Bits 14:8 are the address and bits 7:0 are the data, MSB first.
- R3: A write is stored when chip select rises, and only when exactly 16 rising serial clock edges occurred while selected. Frames with 15 or 17 edges change nothing.
- R4: On a read, the addressed register is shifted out during the second byte. The bit for position 7-k is valid before the (9+k)-th rising edge. The data field sent on the input during a read is ignored.
- R5: The serial output is high-impedance while chip select is high, and driven while it is low.
- R6: After reset the registers read: address 0 = 0x01, address 1 = 0x21, address 2 = 0x00, address 3 = 0x50, address 4 = 0x50, address 5 = 0x03.
- R7: Addresses 0 (revision) and 1 (product) are read-only. Writes to them are ignored.
- R8: Addresses 6 to 127 are unmapped. They read 0x00, and writes to them leave every register unchanged.
- R9: The power register at address 2 keeps only bits 5:2, which drive `ch_off_o[3:0]`; its other bits read 0. The channel register at address 5 keeps only bits 2:0: bit 2 drives `sync_o`, bit 1 drives `load_a_o` and bit 0 drives `load_b_o`.
- R10: The attenuation registers at addresses 3 and 4 keep all 8 bits and drive `att_a_o` and `att_b_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock from host |
| ser_csn_i | input | 1 | Chip select, active low |
| ser_din_i | input | 1 | Serial data from host |
| ser_dout_o | output | 1 | Serial data to host, high-impedance when deselected |
| ch_off_o | output | 4 | Per-channel power-off flags (power register bits 5:2) |
| att_a_o | output | 8 | Attenuation setting, channel A |
| att_b_o | output | 8 | Attenuation setting, channel B |
| sync_o | output | 1 | Channel register bit 2 |
| load_a_o | output | 1 | Channel register bit 1 |
| load_b_o | output | 1 | Channel register bit 0 |

## Verification
The hardest situation to reach from the ports is a frame whose clock count is off by one in either direction. The slave sees a full command byte and a plausible data byte, and must still discard them when chip select rises. The bench builds such frames by driving the serial lines with an explicit edge count of 15 and 17. It then reads the target register back with a correct frame, and also checks the parallel outputs, to show nothing moved. A read frame that carries all-ones in its data field, and a zero-clock select pulse, cover the other ways a write could slip through.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 7;
  localparam int FRAME_BITS = 2 * DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS) + 1;
  localparam int N_ATT      = 2;

  localparam logic [ADDR_W-1:0] A_REV   = 7'd0;
  localparam logic [ADDR_W-1:0] A_PROD  = 7'd1;
  localparam logic [ADDR_W-1:0] A_PWR   = 7'd2;
  localparam logic [ADDR_W-1:0] A_ATT_A = 7'd3;
  localparam logic [ADDR_W-1:0] A_CHAN  = A_ATT_A + ADDR_W'(N_ATT);

  localparam logic [DATA_W-1:0] REV_VAL   = 8'h01;
  localparam logic [DATA_W-1:0] PROD_VAL  = 8'h21;
  localparam logic [DATA_W-1:0] PWR_RST   = 8'h00;
  localparam logic [DATA_W-1:0] ATT_RST   = 8'h50;
  localparam logic [DATA_W-1:0] CHAN_RST  = 8'h03;
  localparam logic [DATA_W-1:0] PWR_MASK  = 8'h3C;
  localparam logic [DATA_W-1:0] CHAN_MASK = 8'h07;
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_rf_frame.sv
module spi_rf_frame
  import spi_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(DATA_W);

  logic                  sclk_d, csn_d;
  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] shreg_q;
  logic [DATA_W-1:0]     cmd_q, out_q;
  logic                  load_pend_q, sdo_q, oe_q, wr_q;
  logic [ADDR_W-1:0]     wr_addr_q;
  logic [DATA_W-1:0]     wr_data_q;

  logic sclk_rise, sclk_fall, cs_fall, cs_rise, in_data_byte;
  assign sclk_rise    = sclk_s & ~sclk_d & ~csn_s;
  assign sclk_fall    = ~sclk_s & sclk_d & ~csn_s;
  assign cs_fall      = ~csn_s & csn_d;
  assign cs_rise      = csn_s & ~csn_d;
  assign in_data_byte = (cnt_q >= CNT_CMD) && (cnt_q < CNT_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d      <= 1'b0;
      csn_d       <= 1'b1;
      cnt_q       <= '0;
      shreg_q     <= '0;
      cmd_q       <= '0;
      out_q       <= '0;
      load_pend_q <= 1'b0;
      sdo_q       <= 1'b0;
      oe_q        <= 1'b0;
      wr_q        <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
    end else begin
      sclk_d      <= sclk_s;
      csn_d       <= csn_s;
      oe_q        <= ~csn_s;
      wr_q        <= 1'b0;
      load_pend_q <= 1'b0;
      if (load_pend_q) out_q <= cmd_q[DATA_W-1] ? rd_data_i : '0;
      if (cs_fall) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        shreg_q <= {shreg_q[FRAME_BITS-2:0], sdi_s};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_CMD - 1'b1) begin
          cmd_q       <= {shreg_q[DATA_W-2:0], sdi_s};
          load_pend_q <= 1'b1;
        end
      end else if (sclk_fall && in_data_byte) begin
        sdo_q <= out_q[DATA_W-1];
        out_q <= {out_q[DATA_W-2:0], 1'b0};
      end
      if (cs_rise && cnt_q == CNT_FULL && !cmd_q[DATA_W-1]) begin
        wr_q      <= 1'b1;
        wr_addr_q <= cmd_q[ADDR_W-1:0];
        wr_data_q <= shreg_q[DATA_W-1:0];
      end
    end
  end

  assign rd_addr_o = cmd_q[ADDR_W-1:0];
  assign wr_en_o   = wr_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = oe_q;

  // R1: a select edge always restarts the bit count
  p_cnt_restart_r1: assert property (@(posedge clk) disable iff (rst)
    $past(cs_fall) |-> cnt_q == '0);
  // R2: serial output moves only after a falling serial clock
  p_sdo_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo_q) |-> $past(sclk_fall));
  // R3: a commit strobe follows a frame of exactly FRAME_BITS edges
  p_commit_exact_r3: assert property (@(posedge clk) disable iff (rst)
    wr_q |-> $past(cnt_q) == CNT_FULL);
  // R5: output enable is off while deselected
  p_oe_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (csn_s && $past(csn_s)) |-> !oe_q);
endmodule

// File: rtl/spi_rf_regs.sv
module spi_rf_regs
  import spi_rf_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic [DATA_W-1:0]           pwr_o,
  output logic [N_ATT-1:0][DATA_W-1:0] att_o,
  output logic [DATA_W-1:0]           chan_o
);
  logic [DATA_W-1:0]            pwr_q, chan_q;
  logic [N_ATT-1:0][DATA_W-1:0] att_q;
  logic                         wr_hit;

  assign wr_hit = wr_en_i && (wr_addr_i >= A_PWR) && (wr_addr_i <= A_CHAN);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q  <= PWR_RST;
      chan_q <= CHAN_RST;
      for (int i = 0; i < N_ATT; i++) att_q[i] <= ATT_RST;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_PWR)  pwr_q  <= wr_data_i & PWR_MASK;
      if (wr_addr_i == A_CHAN) chan_q <= wr_data_i & CHAN_MASK;
      for (int i = 0; i < N_ATT; i++)
        if (wr_addr_i == A_ATT_A + ADDR_W'(i)) att_q[i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_REV)       rd_data_o = REV_VAL;
    else if (rd_addr_i == A_PROD) rd_data_o = PROD_VAL;
    else if (rd_addr_i == A_PWR)  rd_data_o = pwr_q;
    else if (rd_addr_i == A_CHAN) rd_data_o = chan_q;
    else
      for (int i = 0; i < N_ATT; i++)
        if (rd_addr_i == A_ATT_A + ADDR_W'(i)) rd_data_o = att_q[i];
  end

  assign pwr_o  = pwr_q;
  assign att_o  = att_q;
  assign chan_o = chan_q;

  // R7, R8: a write outside the writable window leaves all storage as it was
  p_ignored_write_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !wr_hit) |=> ($stable(pwr_q) && $stable(chan_q) && $stable(att_q)));
  // R9: bits outside the kept fields never become set
  p_field_mask_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en_i) |=> ((pwr_q & ~PWR_MASK) == '0) && ((chan_q & ~CHAN_MASK) == '0));
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
  import spi_rf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ser_clk_i,
  input  logic        ser_csn_i,
  input  logic        ser_din_i,
  output logic        ser_dout_o,
  output logic [3:0]  ch_off_o,
  output logic [7:0]  att_a_o,
  output logic [7:0]  att_b_o,
  output logic        sync_o,
  output logic        load_a_o,
  output logic        load_b_o
);
  logic [2:0]                   sync_q;
  logic [ADDR_W-1:0]            rd_addr, wr_addr;
  logic [DATA_W-1:0]            rd_data, wr_data, pwr, chan;
  logic [N_ATT-1:0][DATA_W-1:0] att;
  logic                         wr_en, sdo, sdo_oe;

  spi_rf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({ser_clk_i, ser_csn_i, ser_din_i}),
    .q_o (sync_q)
  );

  spi_rf_frame u_frame (
    .clk       (clk),
    .rst       (rst),
    .sclk_s    (sync_q[2]),
    .csn_s     (sync_q[1]),
    .sdi_s     (sync_q[0]),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .sdo_o     (sdo),
    .sdo_oe_o  (sdo_oe)
  );

  spi_rf_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .pwr_o     (pwr),
    .att_o     (att),
    .chan_o    (chan)
  );

  assign ser_dout_o = sdo_oe ? sdo : 1'bz;
  assign ch_off_o   = pwr[5:2];
  assign att_a_o    = att[0];
  assign att_b_o    = att[1];
  assign sync_o     = chan[2];
  assign load_a_o   = chan[1];
  assign load_b_o   = chan[0];
endmodule

// File: tb/sim_spi_regfile_slave.sv
module sim_spi_regfile_slave;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
  wire  sdo;
  logic [3:0] ch_off;
  logic [7:0] att_a, att_b;
  logic sync_f, load_a, load_b;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] mdl [6];

  always #10 clk = ~clk;

  spi_regfile_slave u0 (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_csn_i(csn), .ser_din_i(sdi),
    .ser_dout_o(sdo), .ch_off_o(ch_off), .att_a_o(att_a), .att_b_o(att_b),
    .sync_o(sync_f), .load_a_o(load_a), .load_b_o(load_b)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] word, input int nclk, output logic [7:0] rd);
    rd = '0;
    @(negedge clk) csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 16) ? word[15-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i >= 8 && i < 16) rd[15-i] = sdo;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d, input int nclk);
    logic [7:0] unused_rd;
    frame({1'b0, a, d}, nclk, unused_rd);
  endtask

  function automatic logic [7:0] exp_rd(input logic [6:0] a);
    return (a < 7'd6) ? mdl[a] : 8'h00;
  endfunction

  task automatic rd_chk(input logic [6:0] a, input string req);
    logic [7:0] v;
    frame({1'b1, a, 8'hFF}, 16, v);
    chk(v === exp_rd(a), req, {25'd0, a}, {24'd0, exp_rd(a)});
    chk(v === exp_rd(a), req, {24'd0, v}, {24'd0, exp_rd(a)});
  endtask

  task automatic port_chk(input string req);
    chk({ch_off, att_a, att_b, sync_f, load_a, load_b} ===
        {mdl[2][5:2], mdl[3], mdl[4], mdl[5][2:0]}, req,
        {9'd0, ch_off, att_a, att_b, sync_f, load_a, load_b},
        {9'd0, mdl[2][5:2], mdl[3], mdl[4], mdl[5][2:0]});
  endtask

  task automatic mdl_wr(input logic [6:0] a, input logic [7:0] d);
    if (a == 7'd2) mdl[2] = d & 8'h3C;
    else if (a == 7'd5) mdl[5] = d & 8'h07;
    else if (a == 7'd3 || a == 7'd4) mdl[a] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mdl[0] = 8'h01; mdl[1] = 8'h21; mdl[2] = 8'h00;
    mdl[3] = 8'h50; mdl[4] = 8'h50; mdl[5] = 8'h03;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R6 reset state at the ports; R5 output floats while idle
    port_chk("R6 reset outputs");
    chk(sdo === 1'bz, "R5 idle z", {31'd0, sdo}, 32'd0);

    // R5 driven while selected, R1 zero-clock select has no effect
    @(negedge clk) csn = 1'b0;
    repeat (8) @(negedge clk);
    chk(sdo !== 1'bz, "R5 driven when selected", {31'd0, sdo}, 32'd0);
    csn = 1'b1;
    repeat (8) @(negedge clk);
    chk(sdo === 1'bz, "R5 z after release", {31'd0, sdo}, 32'd0);

    // R6 defaults read over the serial link, R4 data field ignored
    for (int a = 0; a < 6; a++) rd_chk(7'(a), "R6 R4 default readback");
    port_chk("R4 read left registers unchanged");

    // R10 attenuation sweep, R2 bit ordering under varied patterns
    for (int v = 0; v < 256; v += 17) begin
      wr(7'd3, 8'(v), 16);        mdl_wr(7'd3, 8'(v));
      wr(7'd4, 8'(255 - v), 16);  mdl_wr(7'd4, 8'(255 - v));
      rd_chk(7'd3, "R10 R2 att A");
      rd_chk(7'd4, "R10 R2 att B");
      port_chk("R10 att ports");
    end

    // R9 field masking for power and channel registers
    for (int k = 0; k < 8; k++) begin
      logic [7:0] pv;
      pv = 8'(k * 37 + 3);
      wr(7'd2, pv, 16);       mdl_wr(7'd2, pv);
      wr(7'd5, ~pv, 16);      mdl_wr(7'd5, ~pv);
      rd_chk(7'd2, "R9 power masked");
      rd_chk(7'd5, "R9 channel masked");
      port_chk("R9 field ports");
    end

    // R7 read-only addresses ignore writes
    wr(7'd0, 8'hA5, 16);
    wr(7'd1, 8'h5A, 16);
    rd_chk(7'd0, "R7 revision read-only");
    rd_chk(7'd1, "R7 product read-only");
    port_chk("R7 no side effect");

    // R3 short and long frames are dropped
    wr(7'd3, 8'hC3, 15);
    rd_chk(7'd3, "R3 short frame dropped");
    wr(7'd4, 8'h3C, 17);
    rd_chk(7'd4, "R3 long frame dropped");
    wr(7'd5, 8'hFF, 4);
    port_chk("R3 R1 aborted frame");
    // R1 a full frame right after an abort still works
    wr(7'd5, 8'h04, 16); mdl_wr(7'd5, 8'h04);
    rd_chk(7'd5, "R1 frame after abort");
    port_chk("R1 ports after abort");

    // R8 unmapped writes ignored, unmapped reads zero
    wr(7'd6, 8'hFF, 16);
    wr(7'd64, 8'hFF, 16);
    wr(7'd127, 8'hFF, 16);
    port_chk("R8 unmapped writes ignored");
    for (int a = 6; a < 128; a++) rd_chk(7'(a), "R8 unmapped read zero");
    chk(sdo === 1'bz, "R5 z at end", {31'd0, sdo}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule